// File: doc/BRIEF.md
# Serial-Chunk Adder/Subtractor

This block adds or subtracts two operands of parameterised width. It does not use one adder as wide as the word. It reuses a single narrow adder slice and walks it across the word from least to most significant, one chunk per enabled clock. The carry out of each chunk is kept in a register and feeds the carry in of the next chunk. The word width does not have to be a multiple of the chunk width. The top chunk is then only partly used, and the carry out of the word is taken from inside that chunk.

Subtraction is A plus the inverted B, with a carry of one into the lowest chunk. Operands and the operation select enter through a ready/valid handshake. The result comes out through a second ready/valid handshake and consists of the sum, the unsigned carry out, the carry into every bit, and the signed overflow flag. The block takes no new operands until the current result has been accepted. A global enable freezes all progress. A synchronous clear drops any operation in flight.

Top module: `serial_chunk_addsub`

## Requirements
- R1: One enabled or disabled clock edge with `clr` high leaves the block idle, with `inReady` = 1 and `outValid` = 0.
- R2: With `subSel` = 0, `sumOut` equals (`opA` + `opB`) modulo 2^WORD_W, for operands captured at the input handshake.
- R3: With `subSel` = 1, `sumOut` equals (`opA` − `opB`) modulo 2^WORD_W.
- R4: `carryOut` is the carry out of the most significant bit of `opA` + (`subSel` ? ~`opB` : `opB`) + `subSel`. For an add this is the unsigned overflow. For a subtract it is 1 exactly when `opA` ≥ `opB` as unsigned values.
- R5: `bitCarries[i]` is the carry into bit i of that same sum, so `bitCarries[0]` equals `subSel`.
- R6: `overflowOut` is 1 exactly when the result, read as a two's-complement number, differs from the true signed sum or difference.
- R7: `outValid` rises after exactly ceil(WORD_W/STEP_W) enabled clock edges, counted from the edge that completes the input handshake. The default parameters (20-bit word, 8-bit chunks, 3 steps, top chunk of 4 bits) exercise the partial top chunk.
- R8: `inReady` stays 0 from the input handshake until the output handshake completes. Changes to `opA`, `opB`, `subSel` and `inValid` during that time do not alter the result.
- R9: While `outValid` = 1 and `outReady` = 0, `outValid` stays 1 and every result output holds its value.
- R10: An edge with `clkEn` = 0 changes no state. Each such edge during an operation adds exactly one cycle to the latency of R7.
- R11: A clear during an operation discards it. The next operation gives a correct result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| clkEn | input | 1 | Global enable; when low, all state holds |
| clr | input | 1 | Synchronous clear back to idle |
| inValid | input | 1 | Operands and select are valid |
| inReady | output | 1 | Block can accept operands |
| subSel | input | 1 | 0 = add, 1 = subtract |
| opA | input | WORD_W | First operand |
| opB | input | WORD_W | Second operand |
| outValid | output | 1 | Result is valid |
| outReady | input | 1 | Consumer takes the result |
| sumOut | output | WORD_W | Sum or difference |
| carryOut | output | 1 | Carry out of the top bit |
| bitCarries | output | WORD_W | Carry into each bit of the sum |
| overflowOut | output | 1 | Signed overflow |

## Verification
Each stored carry between chunks becomes a whole result bit one step later. A wrong carry therefore shows as a sum error at exactly 2^(k·STEP_W) above or below the true value. It also flips the matching `bitCarries` bit, and it appears in the first result handshake after that chunk. A step counter that is off by one shows in two ways: in the count of edges to `outValid`, and as stale or missing bits in the partial top chunk. The partial top chunk also carries `carryOut` and `overflowOut`. Operands with long carry runs, at both signed limits and at both unsigned limits, bring these faults to the ports in the very next result.

// File: rtl/chunk_addsub_pkg.sv
package chunk_addsub_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_HOLD = 2'd2
  } seqState_t;

  typedef struct packed {
    logic load;   // capture operands, seed the carry
    logic step;   // process one chunk
    logic last;   // this step is the top chunk
  } dpStrobe_t;
endpackage

// File: rtl/chunk_slice.sv
module chunk_slice #(
  parameter int STEP_W = 8
) (
  input  logic [STEP_W-1:0] aIn,
  input  logic [STEP_W-1:0] bIn,
  input  logic              cIn,
  output logic [STEP_W-1:0] sumSlice,
  output logic [STEP_W:0]   carrySlice   // carry into bit i; top bit is carry out
);
  always_comb begin
    carrySlice[0] = cIn;
    for (int i = 0; i < STEP_W; i++) begin
      sumSlice[i]     = aIn[i] ^ bIn[i] ^ carrySlice[i];
      carrySlice[i+1] = (aIn[i] & bIn[i]) | (carrySlice[i] & (aIn[i] ^ bIn[i]));
    end
  end
endmodule

// File: rtl/chunk_seq_ctrl.sv
module chunk_seq_ctrl
  import chunk_addsub_pkg::*;
#(
  parameter int NSTEPS = 3,
  parameter int IDX_W  = 2
) (
  input  logic             clk,
  input  logic             clkEn,
  input  logic             clr,
  input  logic             inValid,
  output logic             inReady,
  output logic             outValid,
  input  logic             outReady,
  output dpStrobe_t        strobe,
  output logic [IDX_W-1:0] stepIdx
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NSTEPS - 1);

  seqState_t state;

  always_ff @(posedge clk) begin
    if (clr) begin
      state   <= ST_IDLE;
      stepIdx <= '0;
    end else if (clkEn) begin
      case (state)
        ST_IDLE: if (inValid) begin
          state   <= ST_RUN;
          stepIdx <= '0;
        end
        ST_RUN: if (stepIdx == LAST_IDX) begin
          state   <= ST_HOLD;
          stepIdx <= '0;
        end else begin
          stepIdx <= stepIdx + 1'b1;
        end
        ST_HOLD: if (outReady) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    inReady     = (state == ST_IDLE);
    outValid    = (state == ST_HOLD);
    strobe.load = clkEn && !clr && (state == ST_IDLE) && inValid;
    strobe.step = clkEn && !clr && (state == ST_RUN);
    strobe.last = strobe.step && (stepIdx == LAST_IDX);
  end

  // Step counter used only by the latency check below.
  logic [IDX_W:0] runCnt;
  always_ff @(posedge clk) begin
    if (clr || strobe.load) runCnt <= '0;
    else if (strobe.step)   runCnt <= runCnt + 1'b1;
  end

  // R1
  clear_idle_chk: assert property (@(posedge clk) clr |=> (inReady && !outValid));
  // R8
  accept_block_chk: assert property (@(posedge clk) disable iff (clr)
    (inValid && inReady && clkEn) |=> !inReady);
  // R9
  hold_result_chk: assert property (@(posedge clk) disable iff (clr)
    (outValid && !(outReady && clkEn)) |=> outValid);
  // R10
  freeze_chk: assert property (@(posedge clk) disable iff (clr)
    !clkEn |=> ($stable(state) && $stable(stepIdx)));
  // R7
  latency_chk: assert property (@(posedge clk) disable iff (clr)
    $rose(outValid) |-> (runCnt == (IDX_W+1)'(NSTEPS)));
endmodule

// File: rtl/chunk_addsub_dp.sv
module chunk_addsub_dp
  import chunk_addsub_pkg::*;
#(
  parameter int WORD_W = 20,
  parameter int STEP_W = 8,
  parameter int NSTEPS = 3,
  parameter int PAD_W  = 24,
  parameter int IDX_W  = 2
) (
  input  logic              clk,
  input  logic              clr,
  input  dpStrobe_t         strobe,
  input  logic [IDX_W-1:0]  stepIdx,
  input  logic              subSel,
  input  logic [WORD_W-1:0] opA,
  input  logic [WORD_W-1:0] opB,
  output logic [WORD_W-1:0] sumOut,
  output logic              carryOut,
  output logic [WORD_W-1:0] bitCarries,
  output logic              overflowOut
);
  logic [PAD_W-1:0]  aReg, bReg;       // zero-padded operands; bReg already inverted for subtract
  logic [WORD_W-1:0] sumReg;
  logic [WORD_W:0]   carReg;           // carry into each bit, plus the carry out of the word
  logic              cReg;             // carry between chunks
  logic              subReg;
  logic              done;

  int                baseBit;
  logic [STEP_W-1:0] aChunk, bChunk, sliceSum;
  logic [STEP_W:0]   sliceCar;

  always_comb begin
    baseBit = int'(stepIdx) * STEP_W;
    aChunk  = aReg[baseBit +: STEP_W];
    bChunk  = bReg[baseBit +: STEP_W];
  end

  chunk_slice #(.STEP_W(STEP_W)) uSlice (
    .aIn(aChunk), .bIn(bChunk), .cIn(cReg),
    .sumSlice(sliceSum), .carrySlice(sliceCar)
  );

  always_ff @(posedge clk) begin
    if (strobe.load) begin
      aReg   <= PAD_W'(opA);
      bReg   <= subSel ? PAD_W'(~opB) : PAD_W'(opB);
      cReg   <= subSel;
      subReg <= subSel;
    end else if (strobe.step) begin
      cReg <= sliceCar[STEP_W];
      for (int i = 0; i < STEP_W; i++)
        if (baseBit + i < WORD_W) sumReg[baseBit + i] <= sliceSum[i];
      for (int i = 0; i <= STEP_W; i++)
        if (baseBit + i <= WORD_W) carReg[baseBit + i] <= sliceCar[i];
    end
  end

  always_ff @(posedge clk) begin
    if (clr || strobe.load) done <= 1'b0;
    else if (strobe.last)   done <= 1'b1;
  end

  assign sumOut      = sumReg;
  assign bitCarries  = carReg[WORD_W-1:0];
  assign carryOut    = carReg[WORD_W];
  assign overflowOut = carReg[WORD_W-1] ^ carReg[WORD_W];

  // R2 R3
  wide_sum_chk: assert property (@(posedge clk) disable iff (clr)
    done |-> (sumReg == aReg[WORD_W-1:0] + bReg[WORD_W-1:0] + WORD_W'(subReg)));
  // R6
  sign_ovf_chk: assert property (@(posedge clk) disable iff (clr)
    done |-> (overflowOut == ((aReg[WORD_W-1] == bReg[WORD_W-1]) &&
                              (sumReg[WORD_W-1] != aReg[WORD_W-1]))));
  // R5
  seed_carry_chk: assert property (@(posedge clk) disable iff (clr)
    done |-> (bitCarries[0] == subReg));
endmodule

// File: rtl/serial_chunk_addsub.sv
module serial_chunk_addsub
  import chunk_addsub_pkg::*;
#(
  parameter int WORD_W = 20,
  parameter int STEP_W = 8
) (
  input  logic              clk,
  input  logic              clkEn,
  input  logic              clr,
  input  logic              inValid,
  output logic              inReady,
  input  logic              subSel,
  input  logic [WORD_W-1:0] opA,
  input  logic [WORD_W-1:0] opB,
  output logic              outValid,
  input  logic              outReady,
  output logic [WORD_W-1:0] sumOut,
  output logic              carryOut,
  output logic [WORD_W-1:0] bitCarries,
  output logic              overflowOut
);
  localparam int NSTEPS = (WORD_W + STEP_W - 1) / STEP_W;
  localparam int PAD_W  = NSTEPS * STEP_W;
  localparam int IDX_W  = (NSTEPS > 1) ? $clog2(NSTEPS) : 1;

  dpStrobe_t        strobe;
  logic [IDX_W-1:0] stepIdx;

  chunk_seq_ctrl #(.NSTEPS(NSTEPS), .IDX_W(IDX_W)) uCtrl (
    .clk(clk), .clkEn(clkEn), .clr(clr),
    .inValid(inValid), .inReady(inReady),
    .outValid(outValid), .outReady(outReady),
    .strobe(strobe), .stepIdx(stepIdx)
  );

  chunk_addsub_dp #(
    .WORD_W(WORD_W), .STEP_W(STEP_W), .NSTEPS(NSTEPS), .PAD_W(PAD_W), .IDX_W(IDX_W)
  ) uDp (
    .clk(clk), .clr(clr), .strobe(strobe), .stepIdx(stepIdx),
    .subSel(subSel), .opA(opA), .opB(opB),
    .sumOut(sumOut), .carryOut(carryOut),
    .bitCarries(bitCarries), .overflowOut(overflowOut)
  );

  // R9
  stable_sum_chk: assert property (@(posedge clk) disable iff (clr)
    (outValid && !outReady) |=> $stable(sumOut) && $stable(carryOut) && $stable(overflowOut));
endmodule

// File: tb/serial_chunk_addsub_test.sv
module serial_chunk_addsub_test;
  localparam int CLK_PERIOD = 10;
  localparam int W = 20;
  localparam int S = 8;
  localparam int NST = (W + S - 1) / S;
  localparam logic [W-1:0] MASK = {W{1'b1}};

  logic clk, clkEn, clr, inValid, inReady, subSel, outValid, outReady;
  logic [W-1:0] opA, opB, sumOut, bitCarries;
  logic carryOut, overflowOut;
  int checks = 0, errors = 0;
  bit finished = 0;

  serial_chunk_addsub #(.WORD_W(W), .STEP_W(S)) uut (
    .clk(clk), .clkEn(clkEn), .clr(clr), .inValid(inValid), .inReady(inReady),
    .subSel(subSel), .opA(opA), .opB(opB), .outValid(outValid), .outReady(outReady),
    .sumOut(sumOut), .carryOut(carryOut), .bitCarries(bitCarries), .overflowOut(overflowOut)
  );

  initial begin
    clk = 0;
    forever #(CLK_PERIOD/2) clk = ~clk;
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Reference model written from the requirement text.
  task automatic model(input logic [W-1:0] a, input logic [W-1:0] b, input bit sub,
                       output logic [W-1:0] s, output logic co,
                       output logic [W-1:0] car, output logic ov);
    logic [W-1:0] eb;
    logic [W:0] full;
    eb   = sub ? ~b : b;
    full = {1'b0, a} + {1'b0, eb} + (W+1)'(sub);
    s    = full[W-1:0];
    co   = full[W];
    car  = full[W-1:0] ^ a ^ eb;
    if (!sub) ov = (a[W-1] == b[W-1]) && (s[W-1] != a[W-1]);
    else      ov = (a[W-1] != b[W-1]) && (s[W-1] != a[W-1]);
  endtask

  task automatic runOp(input logic [W-1:0] a, input logic [W-1:0] b, input bit sub,
                       input int enGap, input int stall);
    logic [W-1:0] es, ec, held;
    logic eco, eov;
    int cnt;
    model(a, b, sub, es, eco, ec, eov);
    @(negedge clk);
    chk(inReady == 1'b1, "R8 ready before accept", 64'(inReady), 64'd1);
    inValid = 1; opA = a; opB = b; subSel = sub; outReady = 0;
    @(negedge clk);
    // keep driving junk while busy; it must be ignored (R8)
    opA = $urandom & MASK; opB = $urandom & MASK; subSel = ~sub;
    cnt = 0;
    clkEn = (enGap == 0);
    while (!outValid && cnt < 1000) begin
      chk(inReady == 1'b0, "R8 busy not ready", 64'(inReady), 64'd0);
      @(negedge clk);
      cnt++;
      if (cnt >= enGap) clkEn = 1;
    end
    clkEn = 1;
    chk(cnt == NST + enGap, "R7 R10 latency", 64'(cnt), 64'(NST + enGap));
    chk(sumOut == es, sub ? "R3 difference" : "R2 sum", 64'(sumOut), 64'(es));
    chk(carryOut == eco, "R4 carry out", 64'(carryOut), 64'(eco));
    chk(bitCarries == ec, "R5 bit carries", 64'(bitCarries), 64'(ec));
    chk(overflowOut == eov, "R6 overflow", 64'(overflowOut), 64'(eov));
    held = sumOut;
    for (int i = 0; i < stall; i++) begin
      @(negedge clk);
      chk(outValid && sumOut == held, "R9 held result", 64'(sumOut), 64'(held));
    end
    outReady = 1;
    @(negedge clk);
    outReady = 0; inValid = 0;
    chk(inReady && !outValid, "R8 released after handshake", 64'({inReady, outValid}), 64'b10);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] ra, rb;
    void'($urandom(32'h5eed1234));
    clr = 1; clkEn = 1; inValid = 0; outReady = 0; subSel = 0; opA = '0; opB = '0;
    repeat (3) @(negedge clk);
    clr = 0;
    // R1 reset state
    chk(inReady && !outValid, "R1 reset idle", 64'({inReady, outValid}), 64'b10);

    // directed corners: unsigned wrap, borrow, signed limits
    runOp(MASK, 20'd1, 0, 0, 0);
    runOp(20'd0, 20'd1, 1, 0, 2);
    runOp(20'h7FFFF, 20'd1, 0, 0, 0);
    runOp(20'h80000, 20'd1, 1, 0, 0);
    runOp(20'h80000, 20'h80000, 0, 0, 0);
    runOp(20'h12345, 20'h12345, 1, 0, 0);
    runOp(20'd0, 20'd0, 1, 0, 0);
    runOp(20'h00FFF, 20'h00001, 0, 0, 1);
    runOp(20'h0FFFF, 20'h00001, 0, 3, 0);   // R10 gap
    runOp(20'hABCDE, 20'h54321, 1, 1, 4);

    // R11 clear mid-operation
    @(negedge clk);
    inValid = 1; opA = 20'h11111; opB = 20'h22222; subSel = 0;
    @(negedge clk);
    inValid = 0;
    @(negedge clk);
    clr = 1;
    @(negedge clk);
    clr = 0;
    chk(inReady && !outValid, "R11 R1 clear discards", 64'({inReady, outValid}), 64'b10);
    runOp(20'h33333, 20'h44444, 0, 0, 0);

    for (int n = 0; n < 200; n++) begin
      ra = $urandom & MASK;
      rb = $urandom & MASK;
      runOp(ra, rb, 1'($urandom & 1), int'($urandom % 3), int'($urandom % 3));
    end

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule